// File: doc/BRIEF.md
# Set-Associative Cache with Run-Time Write Policy

This block sits between a processor that issues single-word reads and writes and a next-level memory that moves whole blocks. A word address is split into a tag, a set index and a word offset. A lookup compares the tag against every valid line of the indexed set. On a hit, the word at the offset is returned from that line. On a miss, the block is fetched from the next level and the access is then completed from the cache. The processor port is stalled for as long as the access takes.

A two-bit mode input selects at run time how writes are handled.
- **Write-back** keeps writes in the cache and marks the line dirty. A dirty line is written out before its slot is refilled.
- **Write-through** updates the cached copy and also forwards the word to the next level. The write completes only when the next level acknowledges it.
- **Bypass** sends a write miss straight to the next level without allocating a line.

A set holding a single line gives direct-mapped behaviour. Within a set, replacement prefers an invalid line and otherwise takes the least recently used one. Two counters report how many requests hit and how many missed.

Top module: `assoc_cache`

## Requirements
- R1: Reset clears every valid bit, sets `hit_count` and `miss_count` to zero, and holds `cpu_ready` and `mem_req` low. The first access to any address after reset misses.
- R2: A read hit returns the word selected by the address offset (bits [OFF_W-1:0] of the word address) from the matching line. `cpu_ready` rises two clock edges after the request is taken, with no next-level transfer.
- R3: A read miss issues one next-level block read at block address `cpu_addr >> OFF_W` (tag in the upper bits, set index in bits [SET_W+OFF_W-1:OFF_W] of the word address). It then returns the requested word from the filled block.
- R4: Up to WAYS blocks with different tags and the same set index are resident together, and each of them hits.
- R5: On a miss, an invalid line of the set is filled first. When every line is valid, the least recently accessed line is replaced.
- R6: In write-back mode (`wr_mode` = 1), a write hit updates only the cached word and marks the line dirty. No next-level transfer is made.
- R7: A miss whose victim is dirty first writes the whole victim block out (all `mem_wstrb` bits set, address taken from the victim tag), and only then reads the new block. This makes two transfers.
- R8: In write-through mode (`wr_mode` = 2 or 3), every write updates the cached copy and forwards the word to the next level. The forwarded write sets only the `mem_wstrb` bit equal to the word offset and carries the word on every lane. `cpu_ready` follows `mem_ack`, and lines written this way are evicted without a write-out.
- R9: In bypass mode (`wr_mode` = 0), a write miss is forwarded as a single-word write with no block read and no allocation, so a following read of that address misses.
- R10: Once raised, `mem_req` stays high with `mem_addr` and `mem_we` unchanged until `mem_ack` is seen.
- R11: Each processor request increments exactly one of `hit_count` and `miss_count`, exactly once, including requests that needed a fill.
- R12: `cpu_ready` is a single-cycle pulse, and no new request is accepted in the cycle it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_mode | input | 2 | Write policy: 0 bypass, 1 write-back, 2 or 3 write-through |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | WORD_W | Write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | WORD_W | Read data, valid with `cpu_ready` |
| mem_req | output | 1 | Next-level request |
| mem_we | output | 1 | Next-level write (1) or block read (0) |
| mem_addr | output | ADDR_W-log2(WPL) | Next-level block address |
| mem_wdata | output | WPL*WORD_W | Next-level write block, word i at bits [i*WORD_W +: WORD_W] |
| mem_wstrb | output | WPL | Per-word write enables |
| mem_ack | input | 1 | Next-level acknowledge, one cycle |
| mem_rdata | input | WPL*WORD_W | Block read data, valid with `mem_ack` |
| hit_count | output | CNT_W | Requests that hit |
| miss_count | output | CNT_W | Requests that missed |

## Verification
The bench drives two tags into one set, touches them in a chosen order and then brings in a third tag. A replacement that ignored recency, or overwrote the newest line, would make the kept block miss or the dropped block hit. Dirty victims are checked for both the order of the write-out and the read and for the exact contents written. A design that skipped the write-out, or fetched before writing, would lose the stored words or log the transfers in the wrong order.

In write-through mode the bench checks the strobe on a forwarded word and that a clean eviction produces no write. In bypass mode it checks that a write miss leaves no line behind. The counters are compared against the number of requests, which exposes a design that counts the post-fill retry as a second access.

// File: rtl/ac_pkg.sv
package ac_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_EVICT,
        ST_FILL,
        ST_FWD
    } ac_state_e;

    typedef enum logic [1:0] {
        WM_BYPASS = 2'd0,
        WM_BACK   = 2'd1,
        WM_THRU   = 2'd2,
        WM_THRU2  = 2'd3
    } ac_wmode_e;

    function automatic int ac_idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ac_tags.sv
module ac_tags #(
    parameter int SETS  = 4,
    parameter int WAYS  = 2,
    parameter int SET_W = 2,
    parameter int WAY_W = 1,
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] set_i,
    input  logic [TAG_W-1:0] tag_i,
    input  logic             touch_i,
    input  logic             fill_i,
    input  logic             dirty_i,
    output logic             hit_o,
    output logic [WAY_W-1:0] hit_way_o,
    output logic [WAY_W-1:0] vict_way_o,
    output logic             vict_dirty_o,
    output logic [TAG_W-1:0] vict_tag_o
);

    typedef struct packed {
        logic             valid;
        logic             dirty;
        logic [TAG_W-1:0] tag;
        logic [WAY_W-1:0] age;
    } line_meta_t;

    line_meta_t meta [SETS][WAYS];

    // tag compare across the set
    always_comb begin
        hit_o     = 1'b0;
        hit_way_o = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (meta[set_i][w].valid && meta[set_i][w].tag == tag_i) begin
                hit_o     = 1'b1;
                hit_way_o = WAY_W'(w);
            end
        end
    end

    // victim: first invalid line, else oldest age
    always_comb begin
        logic found;
        found      = 1'b0;
        vict_way_o = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !meta[set_i][w].valid) begin
                found      = 1'b1;
                vict_way_o = WAY_W'(w);
            end
        end
        for (int w = 0; w < WAYS; w++) begin
            if (!found && meta[set_i][w].age == WAY_W'(WAYS - 1)) begin
                found      = 1'b1;
                vict_way_o = WAY_W'(w);
            end
        end
    end

    assign vict_dirty_o = meta[set_i][vict_way_o].valid && meta[set_i][vict_way_o].dirty;
    assign vict_tag_o   = meta[set_i][vict_way_o].tag;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    meta[s][w].valid <= 1'b0;
                    meta[s][w].dirty <= 1'b0;
                    meta[s][w].tag   <= '0;
                    meta[s][w].age   <= WAY_W'(w);
                end
            end
        end else begin
            if (fill_i) begin
                meta[set_i][vict_way_o].valid <= 1'b1;
                meta[set_i][vict_way_o].dirty <= 1'b0;
                meta[set_i][vict_way_o].tag   <= tag_i;
            end
            if (touch_i) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (WAY_W'(w) == hit_way_o)
                        meta[set_i][w].age <= '0;
                    else if (meta[set_i][w].age < meta[set_i][hit_way_o].age)
                        meta[set_i][w].age <= meta[set_i][w].age + 1'b1;
                end
                if (dirty_i)
                    meta[set_i][hit_way_o].dirty <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ac_data.sv
module ac_data #(
    parameter int SETS   = 4,
    parameter int WAYS   = 2,
    parameter int WPL    = 4,
    parameter int WORD_W = 32,
    parameter int SET_W  = 2,
    parameter int WAY_W  = 1,
    parameter int OFF_W  = 2
) (
    input  logic                  clk,
    input  logic [SET_W-1:0]      set_i,
    input  logic [WAY_W-1:0]      way_i,
    input  logic [OFF_W-1:0]      off_i,
    input  logic                  wr_i,
    input  logic [WORD_W-1:0]     wdata_i,
    input  logic                  fill_i,
    input  logic [WPL*WORD_W-1:0] blk_i,
    output logic [WORD_W-1:0]     word_o,
    output logic [WPL*WORD_W-1:0] blk_o
);

    logic [WPL*WORD_W-1:0] lines [SETS][WAYS];

    assign blk_o  = lines[set_i][way_i];
    assign word_o = blk_o[off_i*WORD_W +: WORD_W];

    always_ff @(posedge clk) begin
        if (fill_i)
            lines[set_i][way_i] <= blk_i;
        else if (wr_i)
            lines[set_i][way_i][off_i*WORD_W +: WORD_W] <= wdata_i;
    end

endmodule

// File: rtl/assoc_cache.sv
module assoc_cache
    import ac_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int WORD_W = 32,
    parameter int SETS   = 4,
    parameter int WAYS   = 2,
    parameter int WPL    = 4,
    parameter int CNT_W  = 16
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [1:0]                     wr_mode,
    input  logic                           cpu_req,
    input  logic                           cpu_we,
    input  logic [ADDR_W-1:0]              cpu_addr,
    input  logic [WORD_W-1:0]              cpu_wdata,
    output logic                           cpu_ready,
    output logic [WORD_W-1:0]              cpu_rdata,
    output logic                           mem_req,
    output logic                           mem_we,
    output logic [ADDR_W-$clog2(WPL)-1:0]  mem_addr,
    output logic [WPL*WORD_W-1:0]          mem_wdata,
    output logic [WPL-1:0]                 mem_wstrb,
    input  logic                           mem_ack,
    input  logic [WPL*WORD_W-1:0]          mem_rdata,
    output logic [CNT_W-1:0]               hit_count,
    output logic [CNT_W-1:0]               miss_count
);

    localparam int OFF_W = $clog2(WPL);
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = ac_idx_bits(WAYS);
    localparam int TAG_W = ADDR_W - SET_W - OFF_W;

    ac_state_e          st;
    logic               q_we;
    logic [ADDR_W-1:0]  q_addr;
    logic [WORD_W-1:0]  q_wdata;
    logic               retry;

    logic [TAG_W-1:0]   q_tag;
    logic [SET_W-1:0]   q_set;
    logic [OFF_W-1:0]   q_off;

    logic               hit, vict_dirty;
    logic [WAY_W-1:0]   hit_way, vict_way, sel_way;
    logic [TAG_W-1:0]   vict_tag;
    logic [WORD_W-1:0]  rd_word;
    logic [WPL*WORD_W-1:0] vict_blk;

    logic               m_back, m_bypass;
    logic               touch, mark_dirty, fill_done, word_wr;

    assign q_tag = q_addr[ADDR_W-1 -: TAG_W];
    assign q_set = q_addr[OFF_W +: SET_W];
    assign q_off = q_addr[OFF_W-1:0];

    assign m_back   = (wr_mode == WM_BACK);
    assign m_bypass = (wr_mode == WM_BYPASS);

    assign touch      = (st == ST_LOOK) && hit;
    assign word_wr    = touch && q_we;
    assign mark_dirty = word_wr && m_back;
    assign fill_done  = (st == ST_FILL) && mem_ack;
    assign sel_way    = (st == ST_LOOK) ? hit_way : vict_way;

    ac_tags #(
        .SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W), .TAG_W(TAG_W)
    ) u_tags (
        .clk(clk), .rst(rst),
        .set_i(q_set), .tag_i(q_tag),
        .touch_i(touch), .fill_i(fill_done), .dirty_i(mark_dirty),
        .hit_o(hit), .hit_way_o(hit_way), .vict_way_o(vict_way),
        .vict_dirty_o(vict_dirty), .vict_tag_o(vict_tag)
    );

    ac_data #(
        .SETS(SETS), .WAYS(WAYS), .WPL(WPL), .WORD_W(WORD_W),
        .SET_W(SET_W), .WAY_W(WAY_W), .OFF_W(OFF_W)
    ) u_data (
        .clk(clk),
        .set_i(q_set), .way_i(sel_way), .off_i(q_off),
        .wr_i(word_wr), .wdata_i(q_wdata),
        .fill_i(fill_done), .blk_i(mem_rdata),
        .word_o(rd_word), .blk_o(vict_blk)
    );

    // next-level port
    always_comb begin
        mem_req   = (st == ST_EVICT) || (st == ST_FILL) || (st == ST_FWD);
        mem_we    = (st == ST_EVICT) || (st == ST_FWD);
        mem_addr  = {q_tag, q_set};
        mem_wdata = {WPL{q_wdata}};
        mem_wstrb = '0;
        if (st == ST_EVICT) begin
            mem_addr  = {vict_tag, q_set};
            mem_wdata = vict_blk;
            mem_wstrb = '1;
        end else if (st == ST_FWD) begin
            mem_wstrb = WPL'(1) << q_off;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            q_we       <= 1'b0;
            q_addr     <= '0;
            q_wdata    <= '0;
            retry      <= 1'b0;
            cpu_ready  <= 1'b0;
            cpu_rdata  <= '0;
            hit_count  <= '0;
            miss_count <= '0;
        end else begin
            cpu_ready <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (cpu_req && !cpu_ready) begin
                        q_we    <= cpu_we;
                        q_addr  <= cpu_addr;
                        q_wdata <= cpu_wdata;
                        retry   <= 1'b0;
                        st      <= ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    if (!retry) begin
                        if (hit) hit_count  <= hit_count + CNT_W'(1);
                        else     miss_count <= miss_count + CNT_W'(1);
                    end
                    if (hit) begin
                        if (!q_we) begin
                            cpu_rdata <= rd_word;
                            cpu_ready <= 1'b1;
                            st        <= ST_IDLE;
                        end else if (m_back) begin
                            cpu_ready <= 1'b1;
                            st        <= ST_IDLE;
                        end else begin
                            st <= ST_FWD;
                        end
                    end else if (q_we && m_bypass) begin
                        st <= ST_FWD;
                    end else if (vict_dirty) begin
                        st <= ST_EVICT;
                    end else begin
                        st <= ST_FILL;
                    end
                end
                ST_EVICT: begin
                    if (mem_ack) st <= ST_FILL;
                end
                ST_FILL: begin
                    if (mem_ack) begin
                        retry <= 1'b1;
                        st    <= ST_LOOK;
                    end
                end
                ST_FWD: begin
                    if (mem_ack) begin
                        cpu_ready <= 1'b1;
                        st        <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/assoc_cache_chk.sv
module assoc_cache_chk #(
    parameter int MA_W  = 8,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       wr_mode,
    input logic             cpu_we,
    input logic             cpu_ready,
    input logic             mem_req,
    input logic             mem_we,
    input logic [MA_W-1:0]  mem_addr,
    input logic             mem_ack,
    input logic [CNT_W-1:0] hit_count,
    input logic [CNT_W-1:0] miss_count
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (hit_count == '0 && miss_count == '0 && !cpu_ready && !mem_req));

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> mem_req);

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> ($stable(mem_addr) && $stable(mem_we)));

    // R12
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready);

    // R11
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((hit_count - $past(hit_count)) + (miss_count - $past(miss_count)) <= CNT_W'(1)));

    // R8
    thru_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_ready && cpu_we && wr_mode != 2'd1) |-> $past(mem_ack));

endmodule

bind assoc_cache assoc_cache_chk #(
    .MA_W(ADDR_W - $clog2(WPL)),
    .CNT_W(CNT_W)
) i_chk (
    .clk(clk), .rst(rst), .wr_mode(wr_mode), .cpu_we(cpu_we),
    .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_ack(mem_ack),
    .hit_count(hit_count), .miss_count(miss_count)
);

// File: tb/test_assoc_cache.sv
module test_assoc_cache;

    localparam int MLAT = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  wr_mode = 2'd1;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [9:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        mem_req, mem_we;
    logic [7:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic [3:0]  mem_wstrb;
    logic        mem_ack;
    logic [127:0] mem_rdata;
    logic [15:0] hit_count, miss_count;

    always #4 clk = ~clk;

    assoc_cache i_assoc_cache (
        .clk(clk), .rst(rst), .wr_mode(wr_mode),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    // next-level block memory
    logic [31:0] bm [256][4];
    int          lat_cnt, n_rd, n_wr;
    logic [7:0]  st_addr, l_addr;
    logic [3:0]  l_strb;
    logic        l_we, p_we, addr_bad;

    function automatic logic [31:0] iw(input int blk, input int w);
        return 32'hC000_0000 | (blk << 4) | w;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mem_ack  <= 1'b0;
            lat_cnt  <= 0;
            n_rd     <= 0;
            n_wr     <= 0;
            addr_bad <= 1'b0;
            l_we     <= 1'b0;
            p_we     <= 1'b0;
            l_addr   <= '0;
            l_strb   <= '0;
            st_addr  <= '0;
            mem_rdata <= '0;
            for (int b = 0; b < 256; b++)
                for (int w = 0; w < 4; w++)
                    bm[b][w] <= iw(b, w);
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (lat_cnt == 0) st_addr <= mem_addr;
            if (lat_cnt == MLAT) begin
                lat_cnt <= 0;
                mem_ack <= 1'b1;
                if (mem_addr !== st_addr) addr_bad <= 1'b1;
                if (mem_we) begin
                    for (int w = 0; w < 4; w++)
                        if (mem_wstrb[w]) bm[mem_addr][w] <= mem_wdata[w*32 +: 32];
                    n_wr <= n_wr + 1;
                end else begin
                    for (int w = 0; w < 4; w++)
                        mem_rdata[w*32 +: 32] <= bm[mem_addr][w];
                    n_rd <= n_rd + 1;
                end
                p_we   <= l_we;
                l_we   <= mem_we;
                l_addr <= mem_addr;
                l_strb <= mem_wstrb;
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    int n_chk = 0;
    int n_bad = 0;
    int n_req = 0;
    bit done = 1'b0;

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    function automatic logic [9:0] mk(input int tag, input int set, input int off);
        return {tag[5:0], set[1:0], off[1:0]};
    endfunction

    task automatic access(input logic we, input logic [9:0] a, input logic [31:0] wd,
                          output logic [31:0] rd, output int lat);
        cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_req = 1'b1; lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!cpu_ready && lat < 1000);
        rd = cpu_rdata;
        cpu_req = 1'b0;
        n_req++;
        @(negedge clk);
        chk("R12 ready pulse", {31'b0, cpu_ready}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 hit_count", {16'b0, hit_count}, 32'd0);
        chk("R1 miss_count", {16'b0, miss_count}, 32'd0);
        chk("R1 cpu_ready", {31'b0, cpu_ready}, 32'd0);
        chk("R1 mem_req", {31'b0, mem_req}, 32'd0);
    endtask

    task automatic t_read_basic();
        logic [31:0] rd; int lat; int h0, m0, r0;
        wr_mode = 2'd1;
        m0 = miss_count; r0 = n_rd;
        access(1'b0, mk(1,0,2), 0, rd, lat);
        chk("R3 miss data", rd, iw(4, 2));
        chk("R1 first access misses", miss_count - m0, 1);
        chk("R3 one block read", n_rd - r0, 1);
        chk("R3 block address", {24'b0, l_addr}, 32'd4);
        h0 = hit_count; r0 = n_rd;
        access(1'b0, mk(1,0,3), 0, rd, lat);
        chk("R2 hit data", rd, iw(4, 3));
        chk("R2 hit latency", lat, 2);
        chk("R2 no traffic", n_rd - r0, 0);
        chk("R11 hit counted", hit_count - h0, 1);
    endtask

    task automatic t_assoc_lru();
        logic [31:0] rd; int lat; int h0, m0, w0;
        h0 = hit_count; m0 = miss_count; w0 = n_wr;
        access(1'b0, mk(2,0,0), 0, rd, lat);
        chk("R5 invalid way filled", miss_count - m0, 1);
        access(1'b0, mk(1,0,1), 0, rd, lat);
        chk("R4 first tag resident", rd, iw(4, 1));
        access(1'b0, mk(2,0,1), 0, rd, lat);
        chk("R4 second tag resident", rd, iw(8, 1));
        chk("R4 both hit", hit_count - h0, 2);
        m0 = miss_count;
        access(1'b0, mk(3,0,0), 0, rd, lat);
        chk("R5 third tag misses", miss_count - m0, 1);
        h0 = hit_count;
        access(1'b0, mk(2,0,2), 0, rd, lat);
        chk("R5 recent line kept", hit_count - h0, 1);
        m0 = miss_count;
        access(1'b0, mk(1,0,0), 0, rd, lat);
        chk("R5 LRU line evicted", miss_count - m0, 1);
        chk("R5 clean evictions no write", n_wr - w0, 0);
    endtask

    task automatic t_write_back();
        logic [31:0] rd; int lat; int r0, w0;
        wr_mode = 2'd1;
        r0 = n_rd; w0 = n_wr;
        access(1'b1, mk(5,1,1), 32'hDEAD_0001, rd, lat);
        chk("R6 write miss fills", n_rd - r0, 1);
        r0 = n_rd;
        access(1'b1, mk(5,1,2), 32'hBEEF_0002, rd, lat);
        chk("R6 write hit no traffic", (n_rd - r0) + (n_wr - w0), 0);
        access(1'b0, mk(5,1,1), 0, rd, lat);
        chk("R6 cached value", rd, 32'hDEAD_0001);
        chk("R6 memory untouched", bm[21][1], iw(21, 1));
        access(1'b0, mk(6,1,0), 0, rd, lat);
        r0 = n_rd; w0 = n_wr;
        access(1'b0, mk(7,1,0), 0, rd, lat);
        chk("R7 one write-out", n_wr - w0, 1);
        chk("R7 one fetch", n_rd - r0, 1);
        chk("R7 write before read", {30'b0, p_we, l_we}, 32'd2);
        chk("R7 data after evict", rd, iw(29, 0));
        chk("R7 word1 written out", bm[21][1], 32'hDEAD_0001);
        chk("R7 word2 written out", bm[21][2], 32'hBEEF_0002);
        chk("R7 word0 kept", bm[21][0], iw(21, 0));
    endtask

    task automatic t_write_through();
        logic [31:0] rd; int lat; int r0, w0;
        wr_mode = 2'd2;
        access(1'b0, mk(8,2,0), 0, rd, lat);
        r0 = n_rd; w0 = n_wr;
        access(1'b1, mk(8,2,3), 32'h0000_1234, rd, lat);
        chk("R8 word forwarded", n_wr - w0, 1);
        chk("R8 no fetch on hit", n_rd - r0, 0);
        chk("R8 strobe", {28'b0, l_strb}, 32'h8);
        chk("R8 memory updated", bm[34][3], 32'h0000_1234);
        chk("R8 other words kept", bm[34][0], iw(34, 0));
        w0 = n_wr;
        access(1'b0, mk(8,2,3), 0, rd, lat);
        chk("R8 cached copy", rd, 32'h0000_1234);
        chk("R8 cached read latency", lat, 2);
        access(1'b0, mk(9,2,0), 0, rd, lat);
        access(1'b0, mk(10,2,0), 0, rd, lat);
        chk("R8 clean eviction", n_wr - w0, 0);
    endtask

    task automatic t_bypass();
        logic [31:0] rd; int lat; int r0, w0, m0;
        wr_mode = 2'd0;
        r0 = n_rd; w0 = n_wr; m0 = miss_count;
        access(1'b1, mk(11,3,1), 32'h5555_AAAA, rd, lat);
        chk("R9 forwarded write", n_wr - w0, 1);
        chk("R9 no fetch", n_rd - r0, 0);
        chk("R9 strobe", {28'b0, l_strb}, 32'h2);
        chk("R9 memory word", bm[47][1], 32'h5555_AAAA);
        access(1'b0, mk(11,3,1), 0, rd, lat);
        chk("R9 not allocated", miss_count - m0, 2);
        chk("R9 read returns memory", rd, 32'h5555_AAAA);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_read_basic();
        t_assoc_lru();
        t_write_back();
        t_write_through();
        t_bypass();
        chk("R11 total count", hit_count + miss_count, n_req);
        chk("R10 address held", {31'b0, addr_bad}, 32'd0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule